// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block keeps the hardware breakpoint state of a processor core: four address slots, one control word and one debug status word. The control word gives each slot a local enable, a global enable, a kind (instruction, data write, data read/write or I/O) and a length code. The length code is decoded into a byte count for the memory snooper that sits outside this block. That snooper compares data accesses against the slots and returns one hit pulse per slot.

An evaluation happens in any cycle where the core presents a check or a single-step request. Each instruction-kind slot is compared with the presented instruction pointer. Each data-kind slot takes its hit pulse. The resulting match vector replaces the low status bits, and disabled slots are included in it. The status is written back only when an enabled slot matched, when the core forces the update, or when the request is a single step. The debug-exception request is a registered pulse. It rises in the cycle after an evaluation in which an enabled slot matched or a single step was requested.

Software reaches the registers through a simple select/data port. Selects 0 to 3 are the slot addresses, 4 is the status word and 5 is the control word.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset every slot address reads 0, the control word reads 0x0000_0400, the status word reads 0xFFFF_0FF0 and `dbg_exc` is low.
- R2: A write with select 0..3 stores the slot address, select 5 stores the control word with bit 10 forced to one, and select 4 stores the status word with bits 31..16 and 11..4 forced to one. Selects 6 and 7 read as zero, and writes to them change nothing.
- R3: Slot i counts as enabled when control bit 2i (local) or bit 2i+1 (global) is set.
- R4: The kind of slot i sits in control bits [17+4i:16+4i]: 0 instruction, 1 data write, 2 I/O, 3 data read/write. An instruction-kind slot matches in an evaluation when its address equals `chk_ip` exactly.
- R5: A data-kind slot (kind 1 or 3) matches when its `data_hit` bit is high during the evaluation. An I/O-kind slot never matches, and an instruction-kind slot ignores its `data_hit` bit.
- R6: When the status is updated, bits [3:0] become the match vector of that evaluation, with bit i set for every matching slot i whether it is enabled or not. The other bits keep their value, apart from bit 14 under R9.
- R7: An evaluation without a single step, without `force_upd` and without a match on an enabled slot leaves the status word unchanged. With `force_upd` high, the update of R6 takes place even when nothing enabled matched.
- R8: `dbg_exc` is high in the cycle after an evaluation in which an enabled slot matched, and low in the cycle after one in which no enabled slot matched and no step was requested.
- R9: A `step_req` evaluation always updates the status as in R6, also sets status bit 14, and raises `dbg_exc` in the next cycle.
- R10: `watch_len[4i+3:4i]` gives the byte length of slot i from control bits [19+4i:18+4i]: code 0 gives 1, 1 gives 2, 2 gives 8, 3 gives 4.
- R11: A software write to the status word in an evaluation cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 32 | Combinational read data |
| chk_valid | input | 1 | Request a breakpoint evaluation this cycle |
| chk_ip | input | 32 | Current instruction pointer |
| data_hit | input | 4 | Per-slot data-watch hit pulses |
| force_upd | input | 1 | Write the status even without an enabled hit |
| step_req | input | 1 | Single-step evaluation request |
| dbg_exc | output | 1 | Debug-exception request, registered |
| watch_len | output | 16 | Per-slot decoded watch length in bytes, 4 bits per slot |

## Verification
A wrong decode of the enables or kinds shows up at `dbg_exc` one cycle after the evaluation. The same fault also shows up in the low status nibble, which can be read from that cycle on. A status update that wrongly drops or keeps a value becomes visible only at the next status read. For that reason every scenario first loads a known non-zero low nibble into the status and then reads it back right after the evaluation. Length decode faults appear at once on `watch_len`, with no clock involved.

// File: rtl/dbg_bkpt_pkg.sv
// Shared encodings for the debug breakpoint match unit.
// Assumes the kind and length codes are two bits each.
package dbg_bkpt_pkg;

    typedef enum logic [1:0] {
        KIND_EXEC = 2'd0,
        KIND_DWR  = 2'd1,
        KIND_IO   = 2'd2,
        KIND_DRW  = 2'd3
    } bp_kind_e;

    localparam logic [2:0] SEL_STATUS = 3'd4;
    localparam logic [2:0] SEL_CTRL   = 3'd5;

    // Map a length code to a byte count.
    function automatic logic [3:0] len_to_bytes(input logic [1:0] code);
        logic [3:0] n;
        case (code)
            2'd0:    n = 4'd1;
            2'd1:    n = 4'd2;
            2'd2:    n = 4'd8;
            default: n = 4'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbg_ctrl_decode.sv
// Splits the control word fields into per-slot enable, kind and length.
// Assumes en_bits holds two bits per slot and fld_bits holds the kind/length
// nibbles, one nibble per slot, kind in the low pair.
module dbg_ctrl_decode
    import dbg_bkpt_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic [2*NUM_SLOTS-1:0] en_bits,
    input  logic [4*NUM_SLOTS-1:0] fld_bits,
    output logic [NUM_SLOTS-1:0]   slot_en,
    output logic [2*NUM_SLOTS-1:0] slot_kind,
    output logic [4*NUM_SLOTS-1:0] slot_len
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // Enable is the OR of the local and global bits.
        always_comb begin
            slot_en[g]            = en_bits[2*g] | en_bits[2*g+1];
            slot_kind[2*g +: 2]   = fld_bits[4*g +: 2];
            slot_len[4*g +: 4]    = len_to_bytes(fld_bits[4*g+2 +: 2]);
        end
    end

endmodule

// File: rtl/dbg_slot_match.sv
// Match condition for one breakpoint slot during an evaluation.
// Assumes data_hit_i is already qualified by the external snooper.
module dbg_slot_match
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [1:0]        kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] ip_i,
    input  logic              data_hit_i,
    output logic              match_o
);

    // Select the match source from the slot kind.
    always_comb begin
        match_o = 1'b0;
        if (eval_i) begin
            case (bp_kind_e'(kind_i))
                KIND_EXEC:          match_o = (addr_i == ip_i);
                KIND_DWR, KIND_DRW: match_o = data_hit_i;
                default:            match_o = 1'b0;
            endcase
        end
    end

    // R5: an I/O slot never reports a match.
    a_r5_io_never_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 2'd2) |-> !match_o);

    // R4: an instruction slot match implies equal addresses.
    a_r4_exec_needs_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && kind_i == 2'd0) |-> (addr_i == ip_i));

endmodule

// File: rtl/dbg_status_reg.sv
// Debug status register and registered exception request.
// Assumes match_i is zero outside evaluations and that the low NUM_SLOTS
// bits and STEP_BIT are not among the fixed-one bits.
module dbg_status_reg #(
    parameter int              DATA_W    = 32,
    parameter int              NUM_SLOTS = 4,
    parameter int              STEP_BIT  = 14,
    parameter logic [DATA_W-1:0] ONES    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic              step_i,
    input  logic              force_i,
    input  logic [NUM_SLOTS-1:0] match_i,
    input  logic [NUM_SLOTS-1:0] en_i,
    input  logic              sw_we_i,
    input  logic [DATA_W-1:0] sw_data_i,
    output logic [DATA_W-1:0] stat_o,
    output logic              exc_o
);

    logic              hit_en;
    logic              do_upd;
    logic [DATA_W-1:0] upd_val;

    // Build the update value and decide whether it is written.
    always_comb begin
        hit_en  = |(match_i & en_i);
        do_upd  = eval_i && (hit_en || force_i || step_i);
        upd_val = stat_o;
        upd_val[NUM_SLOTS-1:0] = match_i;
        if (step_i) begin
            upd_val[STEP_BIT] = 1'b1;
        end
    end

    // Status register: evaluation update wins over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_o <= ONES;
        end else if (do_upd) begin
            stat_o <= upd_val;
        end else if (sw_we_i && !eval_i) begin
            stat_o <= sw_data_i | ONES;
        end
    end

    // Exception request, one cycle after the causing evaluation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_o <= 1'b0;
        end else begin
            exc_o <= eval_i && (hit_en || step_i);
        end
    end

    // R8: an exception always follows an evaluation.
    a_r8_exc_needs_eval: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> $past(eval_i));

    // R9: a step sets its flag and raises the exception.
    a_r9_step_flag_and_exc: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (exc_o && stat_o[STEP_BIT]));

    // R7: no cause, no status change.
    a_r7_hold_without_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && !step_i && !force_i && ((match_i & en_i) == '0)) |=> $stable(stat_o));

    // R6: a forced update copies the match vector into the low bits.
    a_r6_low_bits_follow_match: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_i && force_i) |=> (stat_o[NUM_SLOTS-1:0] == $past(match_i)));

    // R2: fixed-one status bits stay set.
    a_r2_status_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o & ONES) == ONES);

endmodule

// File: rtl/dbg_bkpt_unit.sv
// Top of the debug breakpoint match unit: slot address registers, control
// word, register read mux, per-slot match logic and the status register.
// Assumes NUM_SLOTS is 4 or less so the control fields fit in DATA_W = 32.
module dbg_bkpt_unit
    import dbg_bkpt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4,
    parameter int SEL_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [DATA_W-1:0]      rd_data,
    input  logic                   chk_valid,
    input  logic [DATA_W-1:0]      chk_ip,
    input  logic [NUM_SLOTS-1:0]   data_hit,
    input  logic                   force_upd,
    input  logic                   step_req,
    output logic                   dbg_exc,
    output logic [4*NUM_SLOTS-1:0] watch_len
);

    localparam int FLD_BASE   = 16;
    localparam int STEP_BIT   = 14;
    localparam int CTRL_FIXED = 10;
    localparam logic [DATA_W-1:0] CTRL_ONES = DATA_W'(1) << CTRL_FIXED;
    localparam logic [DATA_W-1:0] STAT_ONES = {{(DATA_W-16){1'b1}}, 16'h0FF0};

    logic [DATA_W-1:0]      slot_addr [NUM_SLOTS];
    logic [DATA_W-1:0]      ctrl_q;
    logic [DATA_W-1:0]      stat_q;
    logic [NUM_SLOTS-1:0]   slot_en;
    logic [2*NUM_SLOTS-1:0] slot_kind;
    logic [NUM_SLOTS-1:0]   slot_match;
    logic                   eval;
    logic                   stat_we;

    assign eval    = chk_valid | step_req;
    assign stat_we = wr_en && (wr_sel == SEL_STATUS);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_addr
        // Slot address register, written by its own select value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[g] <= '0;
            end else if (wr_en && wr_sel == SEL_W'(g)) begin
                slot_addr[g] <= wr_data;
            end
        end
    end

    // Control word register with its fixed-one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_ONES;
        end else if (wr_en && wr_sel == SEL_CTRL) begin
            ctrl_q <= wr_data | CTRL_ONES;
        end
    end

    // Register read mux; unused selects read zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_sel == SEL_W'(i)) begin
                rd_data = slot_addr[i];
            end
        end
        if (rd_sel == SEL_STATUS) begin
            rd_data = stat_q;
        end
        if (rd_sel == SEL_CTRL) begin
            rd_data = ctrl_q;
        end
    end

    dbg_ctrl_decode #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_decode (
        .en_bits   (ctrl_q[2*NUM_SLOTS-1:0]),
        .fld_bits  (ctrl_q[FLD_BASE +: 4*NUM_SLOTS]),
        .slot_en   (slot_en),
        .slot_kind (slot_kind),
        .slot_len  (watch_len)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_match
        dbg_slot_match #(
            .ADDR_W (DATA_W)
        ) u_match (
            .clk        (clk),
            .rst_n      (rst_n),
            .eval_i     (eval),
            .kind_i     (slot_kind[2*g +: 2]),
            .addr_i     (slot_addr[g]),
            .ip_i       (chk_ip),
            .data_hit_i (data_hit[g]),
            .match_o    (slot_match[g])
        );
    end

    dbg_status_reg #(
        .DATA_W    (DATA_W),
        .NUM_SLOTS (NUM_SLOTS),
        .STEP_BIT  (STEP_BIT),
        .ONES      (STAT_ONES)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_i    (eval),
        .step_i    (step_req),
        .force_i   (force_upd),
        .match_i   (slot_match),
        .en_i      (slot_en),
        .sw_we_i   (stat_we),
        .sw_data_i (wr_data),
        .stat_o    (stat_q),
        .exc_o     (dbg_exc)
    );

    // R2: the control fixed-one bit never clears.
    a_r2_ctrl_fixed_one: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTRL_FIXED]);

    // R11: a status write during an evaluation without update leaves status alone.
    a_r11_write_lost_in_eval: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && eval && !step_req && !force_upd && ((slot_match & slot_en) == '0))
        |=> $stable(stat_q));

endmodule

// File: tb/tb_dbg_bkpt_unit.sv
module tb_dbg_bkpt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        chk_valid = 1'b0;
    logic [31:0] chk_ip = '0;
    logic [3:0]  data_hit = '0;
    logic        force_upd = 1'b0;
    logic        step_req = 1'b0;
    logic        dbg_exc;
    logic [15:0] watch_len;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dbg_bkpt_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .chk_valid(chk_valid), .chk_ip(chk_ip), .data_hit(data_hit),
        .force_upd(force_upd), .step_req(step_req), .dbg_exc(dbg_exc),
        .watch_len(watch_len)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic evaluate(input logic [31:0] ip, input logic [3:0] hits,
                            input logic frc, input logic stp);
        chk_valid = ~stp; chk_ip = ip; data_hit = hits; force_upd = frc; step_req = stp;
        tick();
        chk_valid = 1'b0; data_hit = '0; force_upd = 1'b0; step_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), d);
            check("R1 addr", d, 32'h0);
        end
        rd(3'd4, d); check("R1 status", d, 32'hFFFF_0FF0);
        rd(3'd5, d); check("R1 ctrl", d, 32'h0000_0400);
        check("R1 exc", {31'b0, dbg_exc}, 32'h0);
        check("R10 reset len", {16'b0, watch_len}, 32'h1111);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(3'd0, 32'h1000); wr(3'd1, 32'h3000); wr(3'd2, 32'h2000); wr(3'd3, 32'h5000);
        rd(3'd0, d); check("R2 addr0", d, 32'h1000);
        rd(3'd1, d); check("R2 addr1", d, 32'h3000);
        rd(3'd3, d); check("R2 addr3", d, 32'h5000);
        wr(3'd5, 32'h0); rd(3'd5, d); check("R2 ctrl fixed", d, 32'h0000_0400);
        wr(3'd4, 32'h0000_1003); rd(3'd4, d); check("R2 status fixed", d, 32'hFFFF_1FF3);
        wr(3'd6, 32'hDEAD_BEEF); rd(3'd6, d); check("R2 sel6 zero", d, 32'h0);
        rd(3'd2, d); check("R2 sel6 no effect", d, 32'h2000);
    endtask

    task automatic t_len();
        wr(3'd5, (32'h1 << 22) | (32'h1 << 27) | (32'h3 << 30));
        #1;
        check("R10 len decode", {16'b0, watch_len}, 32'h4821);
    endtask

    task automatic t_exec_local();
        logic [31:0] d;
        wr(3'd4, 32'h0); wr(3'd5, 32'h1);
        evaluate(32'h1000, 4'h0, 1'b0, 1'b0);
        check("R8 exc after hit", {31'b0, dbg_exc}, 32'h1);
        rd(3'd4, d); check("R4 exec local hit", d, 32'hFFFF_0FF1);
        tick();
        check("R8 exc pulse ends", {31'b0, dbg_exc}, 32'h0);
    endtask

    task automatic t_exec_global();
        logic [31:0] d;
        wr(3'd4, 32'h0); wr(3'd5, 32'h1 << 5);
        evaluate(32'h2000, 4'h0, 1'b0, 1'b0);
        check("R3 global exc", {31'b0, dbg_exc}, 32'h1);
        rd(3'd4, d); check("R3 global status", d, 32'hFFFF_0FF4);
    endtask

    task automatic t_disabled_hold();
        logic [31:0] d;
        wr(3'd4, 32'h5); wr(3'd5, 32'h1);
        evaluate(32'h3000, 4'h0, 1'b0, 1'b0);
        check("R8 no exc on disabled", {31'b0, dbg_exc}, 32'h0);
        rd(3'd4, d); check("R7 status held", d, 32'hFFFF_0FF5);
    endtask

    task automatic t_mixed();
        logic [31:0] d;
        wr(3'd4, 32'h0); wr(3'd5, 32'h1); wr(3'd1, 32'h1000);
        evaluate(32'h1000, 4'h0, 1'b0, 1'b0);
        check("R8 mixed exc", {31'b0, dbg_exc}, 32'h1);
        rd(3'd4, d); check("R6 disabled recorded", d, 32'hFFFF_0FF3);
        wr(3'd1, 32'h3000);
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(3'd4, 32'h8); wr(3'd5, 32'h1);
        evaluate(32'h3000, 4'h0, 1'b1, 1'b0);
        check("R7 force no exc", {31'b0, dbg_exc}, 32'h0);
        rd(3'd4, d); check("R7 forced update", d, 32'hFFFF_0FF2);
        evaluate(32'h9999, 4'h0, 1'b1, 1'b0);
        rd(3'd4, d); check("R6 forced clear", d, 32'hFFFF_0FF0);
    endtask

    task automatic t_data();
        logic [31:0] d;
        wr(3'd4, 32'h0); wr(3'd5, 32'h3000_0040);
        evaluate(32'h0, 4'h8, 1'b0, 1'b0);
        check("R5 drw exc", {31'b0, dbg_exc}, 32'h1);
        rd(3'd4, d); check("R5 drw status", d, 32'hFFFF_0FF8);
        wr(3'd5, 32'h0010_0004);
        evaluate(32'h0, 4'h2, 1'b0, 1'b0);
        check("R5 dwr exc", {31'b0, dbg_exc}, 32'h1);
        rd(3'd4, d); check("R5 dwr status", d, 32'hFFFF_0FF2);
    endtask

    task automatic t_io_ignore();
        logic [31:0] d;
        wr(3'd4, 32'hF); wr(3'd5, 32'h0200_0011);
        evaluate(32'h2000, 4'h5, 1'b1, 1'b0);
        check("R5 io no exc", {31'b0, dbg_exc}, 32'h0);
        rd(3'd4, d); check("R5 io and exec ignore hits", d, 32'hFFFF_0FF0);
    endtask

    task automatic t_step();
        logic [31:0] d;
        wr(3'd4, 32'h0); wr(3'd5, 32'h0);
        evaluate(32'h0, 4'h0, 1'b0, 1'b1);
        check("R9 step exc", {31'b0, dbg_exc}, 32'h1);
        rd(3'd4, d); check("R9 step flag", d, 32'hFFFF_4FF0);
        tick();
        check("R9 step pulse ends", {31'b0, dbg_exc}, 32'h0);
        evaluate(32'h1000, 4'h0, 1'b0, 1'b1);
        rd(3'd4, d); check("R9 step records disabled", d, 32'hFFFF_4FF1);
    endtask

    task automatic t_write_collision();
        logic [31:0] d;
        wr(3'd4, 32'h0); wr(3'd5, 32'h1);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'h7;
        evaluate(32'h3000, 4'h0, 1'b0, 1'b0);
        wr_en = 1'b0;
        rd(3'd4, d); check("R11 write dropped", d, 32'hFFFF_0FF0);
        wr(3'd4, 32'h7);
        rd(3'd4, d); check("R11 write outside eval", d, 32'hFFFF_0FF7);
    endtask

    task automatic t_back_to_back();
        wr(3'd5, 32'h1);
        evaluate(32'h1000, 4'h0, 1'b0, 1'b0);
        evaluate(32'h1000, 4'h0, 1'b0, 1'b0);
        check("R8 second hit exc", {31'b0, dbg_exc}, 32'h1);
        tick();
        check("R8 idle exc low", {31'b0, dbg_exc}, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_len();
        t_exec_local();
        t_exec_global();
        t_disabled_hold();
        t_mixed();
        t_force();
        t_data();
        t_io_ignore();
        t_step();
        t_write_collision();
        t_back_to_back();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule